// File: doc/BRIEF.md
# Embedded-Clock Serial Frame Deframer

The deframer takes a serial bitstream that has already been sampled, one bit per fast clock. The stream carries back-to-back 28-bit frames. Each frame starts with a fixed high clock bit and ends with a fixed low clock bit. Between them sit 24 payload bits, an inversion flag and an even-parity bit.

The block uses the high/low clock-bit pair as its only alignment reference. It slides its frame window one bit at a time until the pair repeats at the same position, with no training sequence needed. It then declares lock and starts decoding. For each aligned frame it undoes the DC-balance inversion, checks parity and presents the 24-bit word with a one-cycle valid strobe. The three top payload bits are also copied to separate side outputs.

Three controls set the output behaviour:
- Power-down forces a fresh search.
- Output-enable blanks the parallel side.
- An output-state select decides whether unaligned data is hidden or shown while unlocked.

Top module: `frame_deframer`

## Requirements
- R1: Frame bit order on `ser_i`, first bit received first. Position 0 is the high clock bit. Positions 1..24 carry payload bits 0..23. Position 25 is the inversion flag. Position 26 is the parity bit. Position 27 is the low clock bit.
- R2: `lock_o` stays low until 16 consecutive frames at one candidate offset show high at position 0 and low at position 27. It rises in the cycle after the last bit of the 16th such frame is sampled.
- R3: While unlocked, a frame whose clock pair is wrong moves the candidate offset by one bit and clears the run count. The block therefore locks from any starting bit offset.
- R4: When the inversion flag is 1, `data_o` is the bitwise inverse of the received payload bits. When the flag is 0, `data_o` is the payload as received.
- R5: While locked, a frame whose payload, inversion flag and parity bit do not have even parity pulses `err_o` together with `valid_o`. Lock is not affected.
- R6: While locked, up to 3 consecutive frames with a wrong clock pair keep `lock_o` high and each pulses `err_o`. The 4th consecutive one drops `lock_o` in the cycle after its last bit.
- R7: While locked, `valid_o` is a one-cycle pulse in the cycle after each frame's last bit, so valid pulses are 28 cycles apart.
- R8: `side_o[0]`, `side_o[1]` and `side_o[2]` equal `data_o` bits 21, 22 and 23.
- R9: While unlocked, `valid_o` is low. With `oss_i` low, `data_o` is zero. With `oss_i` high, `data_o` shows the word decoded at the current candidate offset.
- R10: With `oe_i` low, `data_o`, `side_o`, `valid_o` and `err_o` are zero. `lock_o` is unaffected.
- R11: `pd_i` high drops `lock_o` in the next cycle and holds the search at its start. After release, lock is reacquired from any offset.
- R12: After reset, `lock_o`, `valid_o`, `err_o`, `data_o` and `side_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_i | input | 1 | Power-down; holds search at start |
| oe_i | input | 1 | Output enable for the parallel side |
| oss_i | input | 1 | Show unaligned data while unlocked |
| ser_i | input | 1 | Sampled serial bit |
| data_o | output | 24 | Decoded payload word |
| valid_o | output | 1 | One-cycle strobe per decoded locked frame |
| lock_o | output | 1 | Frame alignment achieved |
| err_o | output | 1 | Parity or clock-pair error on the strobed frame |
| side_o | output | 3 | Payload bits 23..21 as level signals |

## Verification
Frames are drawn at random, with a random inversion flag so that both decode paths appear. Frame alignment is tried from the exact boundary at reset, from a one-bit shift after a lock loss, and from a random bit offset after power-down. Together these separate a correct slip from a lucky start.

Parity faults and clock-pair faults are injected in short and long runs. This shows that isolated faults only flag errors, while a run of four loses lock. Blanking, unlocked hiding and unlocked pass-through are each held over whole frames, which distinguishes them from a gate that acts only on the strobe.

// File: rtl/deframer_pkg.sv
package deframer_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } lock_state_e;
endpackage

// File: rtl/frame_align.sv
module frame_align #(
  parameter int unsigned FRAME_LEN = 28
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pd_i,
  input  logic                 bit_i,
  input  logic                 slip_i,
  output logic                 eval_o,
  output logic [FRAME_LEN-1:0] window_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [FRAME_LEN-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (pd_i) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      sr_q <= {sr_q[FRAME_LEN-3:0], bit_i};
      if (cnt_q == LAST) cnt_q <= slip_i ? CNT_W'(1) : '0; // skip a bit to shift offset
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // oldest bit at MSB, current bit at LSB
  assign window_o = {sr_q, bit_i};
  assign eval_o   = (cnt_q == LAST) && !pd_i;

  AST_SLIP_AT_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |-> eval_o); // R3
endmodule

// File: rtl/frame_decode.sv
module frame_decode #(
  parameter int unsigned PAYLOAD_W = 24
) (
  input  logic [PAYLOAD_W+3:0] window_i,
  output logic [PAYLOAD_W-1:0] payload_o,
  output logic                 clk_ok_o,
  output logic                 par_ok_o
);
  localparam int unsigned FL = PAYLOAD_W + 4;

  logic [PAYLOAD_W-1:0] raw;
  logic                 inv;
  logic                 par;

  for (genvar j = 0; j < PAYLOAD_W; j++) begin : g_pick
    assign raw[j] = window_i[FL-2-j];
  end

  assign inv       = window_i[2];
  assign par       = window_i[1];
  assign clk_ok_o  = window_i[FL-1] & ~window_i[0];
  assign par_ok_o  = ~(^{raw, inv, par});
  assign payload_o = raw ^ {PAYLOAD_W{inv}};
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import deframer_pkg::*;
#(
  parameter int unsigned LOCK_FRAMES   = 16,
  parameter int unsigned UNLOCK_FRAMES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic eval_i,
  input  logic clk_ok_i,
  output logic locked_o,
  output logic slip_o
);
  localparam int unsigned GW = $clog2(LOCK_FRAMES + 1);
  localparam int unsigned BW = $clog2(UNLOCK_FRAMES + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_FRAMES - 1);
  localparam logic [BW-1:0] BAD_LAST  = BW'(UNLOCK_FRAMES - 1);

  lock_state_e   state_q;
  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;

  assign locked_o = (state_q == ST_LOCKED);
  assign slip_o   = eval_i && !clk_ok_i &&
                    ((state_q == ST_SEARCH) || (bad_q == BAD_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      good_q  <= '0;
      bad_q   <= '0;
    end else if (pd_i) begin
      state_q <= ST_SEARCH;
      good_q  <= '0;
      bad_q   <= '0;
    end else if (eval_i) begin
      unique case (state_q)
        ST_SEARCH: begin
          if (!clk_ok_i) good_q <= '0;
          else if (good_q == GOOD_LAST) begin
            state_q <= ST_LOCKED;
            good_q  <= '0;
            bad_q   <= '0;
          end else good_q <= good_q + 1'b1;
        end
        ST_LOCKED: begin
          if (clk_ok_i) bad_q <= '0;
          else if (bad_q == BAD_LAST) begin
            state_q <= ST_SEARCH;
            bad_q   <= '0;
            good_q  <= '0;
          end else bad_q <= bad_q + 1'b1;
        end
        default: state_q <= ST_SEARCH;
      endcase
    end
  end

  AST_LOCK_RISE_AT_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(eval_i) && $past(clk_ok_i)); // R2
  AST_LOCK_FALL_AT_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(pd_i) || ($past(eval_i) && !$past(clk_ok_i))); // R6
  AST_PD_DROPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !locked_o); // R11
endmodule

// File: rtl/frame_deframer.sv
module frame_deframer #(
  parameter int unsigned PAYLOAD_W     = 24,
  parameter int unsigned SIDE_W        = 3,
  parameter int unsigned LOCK_FRAMES   = 16,
  parameter int unsigned UNLOCK_FRAMES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pd_i,
  input  logic                 oe_i,
  input  logic                 oss_i,
  input  logic                 ser_i,
  output logic [PAYLOAD_W-1:0] data_o,
  output logic                 valid_o,
  output logic                 lock_o,
  output logic                 err_o,
  output logic [SIDE_W-1:0]    side_o
);
  localparam int unsigned FRAME_LEN = PAYLOAD_W + 4;

  logic                 eval;
  logic [FRAME_LEN-1:0] window;
  logic                 slip;
  logic [PAYLOAD_W-1:0] payload;
  logic                 clk_ok;
  logic                 par_ok;
  logic                 locked;

  logic [PAYLOAD_W-1:0] data_q;
  logic                 valid_q;
  logic                 err_q;
  logic                 show;

  frame_align #(.FRAME_LEN(FRAME_LEN)) u_align (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_i     (pd_i),
    .bit_i    (ser_i),
    .slip_i   (slip),
    .eval_o   (eval),
    .window_o (window)
  );

  frame_decode #(.PAYLOAD_W(PAYLOAD_W)) u_decode (
    .window_i  (window),
    .payload_o (payload),
    .clk_ok_o  (clk_ok),
    .par_ok_o  (par_ok)
  );

  lock_fsm #(
    .LOCK_FRAMES   (LOCK_FRAMES),
    .UNLOCK_FRAMES (UNLOCK_FRAMES)
  ) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_i     (pd_i),
    .eval_i   (eval),
    .clk_ok_i (clk_ok),
    .locked_o (locked),
    .slip_o   (slip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (pd_i) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= eval && locked;
      err_q   <= eval && locked && !(clk_ok && par_ok);
      if (eval) data_q <= payload;
    end
  end

  // a strobe on the frame that drops lock still carries its word
  assign show    = oe_i && (locked || valid_q || oss_i);
  assign data_o  = show ? data_q : '0;
  assign side_o  = data_o[PAYLOAD_W-1 -: SIDE_W];
  assign valid_o = oe_i && valid_q;
  assign err_o   = oe_i && err_q;
  assign lock_o  = locked;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R7
  AST_VALID_AFTER_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(eval) && $past(locked)); // R7
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> valid_q && $past(!clk_ok || !par_ok)); // R5
endmodule

// File: tb/frame_deframer_tb.sv
module frame_deframer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pd_i = 1'b0;
  logic        oe_i = 1'b1;
  logic        oss_i = 1'b0;
  logic        ser_i = 1'b0;
  logic [23:0] data_o;
  logic        valid_o;
  logic        lock_o;
  logic        err_o;
  logic [2:0]  side_o;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int last_valid_cyc = -1000;
  int inv_seen = 0;
  int plain_seen = 0;
  int err_pulses = 0;
  int valid_count = 0;
  logic [23:0] exp_data = '0;
  logic        exp_err = 1'b0;
  logic        exp_inv = 1'b0;
  bit          finished = 0;

  frame_deframer dut_i (
    .clk_i, .rst_ni, .pd_i, .oe_i, .oss_i, .ser_i,
    .data_o, .valid_o, .lock_o, .err_o, .side_o
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // one 28-bit frame, first bit first, returns at the negedge driving the last bit
  task automatic send_frame(input logic [23:0] word, input bit inv,
                            input bit bad_par, input bit bad_clk);
    logic [27:0] fb;
    logic [23:0] sent;
    sent = inv ? ~word : word;
    fb[0] = bad_clk ? 1'b0 : 1'b1;
    for (int j = 0; j < 24; j++) fb[1+j] = sent[j];
    fb[25] = inv;
    fb[26] = (^{sent, inv}) ^ bad_par;
    fb[27] = 1'b0;
    for (int b = 0; b < 28; b++) begin
      @(negedge clk_i);
      ser_i = fb[b];
      if (b == 27) begin
        exp_data = word;
        exp_err  = bad_par | bad_clk;
        exp_inv  = inv;
      end
    end
  endtask

  task automatic send_random(input int n);
    for (int k = 0; k < n; k++) send_frame($urandom & 24'hFFFFFF, $urandom & 1, 0, 0);
  endtask

  // per-strobe checks of word, side bits, error and spacing
  always @(posedge clk_i) begin
    #2;
    if (valid_o && rst_ni) begin
      valid_count++;
      check(data_o == exp_data, "R1", "decoded word", data_o, exp_data);
      check(side_o == exp_data[23:21], "R8", "side bits", side_o, exp_data[23:21]);
      check(err_o == exp_err, "R5", "error flag", err_o, exp_err);
      check(cyc - last_valid_cyc >= 28, "R7", "strobe spacing", cyc - last_valid_cyc, 28);
      last_valid_cyc = cyc;
      if (err_o) err_pulses++;
      if (data_o == exp_data && !exp_err) begin
        if (exp_inv) inv_seen++; else plain_seen++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    check(0, "WDOG", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int dummy;
    int v0;
    int e0;
    bit ok;
    bit nz;
    dummy = $urandom(32'h1D2C);

    repeat (3) @(posedge clk_i);
    #2;
    check(!lock_o && !valid_o && !err_o && data_o == 0 && side_o == 0, "R12", "reset state",
          {lock_o, valid_o, err_o, side_o}, 0);
    @(posedge clk_i);
    #2 rst_ni = 1'b1;

    // aligned start: lock after exactly 16 frames
    send_random(15);
    @(posedge clk_i); #2;
    check(!lock_o, "R2", "lock before 16th frame", lock_o, 0);
    send_random(1);
    @(posedge clk_i); #2;
    check(lock_o, "R2", "lock after 16th frame", lock_o, 1);

    // random traffic with both inversion settings
    v0 = valid_count;
    send_random(60);
    @(posedge clk_i); #2;
    check(valid_count - v0 == 60, "R7", "one strobe per frame", valid_count - v0, 60);
    check(inv_seen > 0 && plain_seen > 0, "R4", "both inversion paths decoded", inv_seen, 1);
    send_frame(24'hE00000, 1, 0, 0);
    send_frame(24'h1FFFFF, 0, 0, 0);
    send_frame(24'h000000, 1, 0, 0);
    send_frame(24'hFFFFFF, 0, 0, 0);

    // parity faults keep lock
    e0 = err_pulses;
    send_frame(24'h5A5A5A, 0, 1, 0);
    send_frame(24'hA5A5A5, 1, 1, 0);
    send_random(2);
    @(posedge clk_i); #2;
    check(err_pulses - e0 == 2, "R5", "parity error pulses", err_pulses - e0, 2);
    check(lock_o, "R5", "lock held over parity errors", lock_o, 1);

    // three bad clock pairs keep lock
    e0 = err_pulses;
    for (int k = 0; k < 3; k++) send_frame($urandom & 24'hFFFFFF, $urandom & 1, 0, 1);
    send_random(1);
    @(posedge clk_i); #2;
    check(lock_o, "R6", "lock held over 3 bad clock pairs", lock_o, 1);
    check(err_pulses - e0 == 3, "R6", "clock error pulses", err_pulses - e0, 3);

    // four bad clock pairs drop lock
    for (int k = 0; k < 3; k++) send_frame($urandom & 24'hFFFFFF, 0, 0, 1);
    @(posedge clk_i); #2;
    check(lock_o, "R6", "lock held after 3rd bad", lock_o, 1);
    send_frame($urandom & 24'hFFFFFF, 0, 0, 1);
    @(posedge clk_i); #2;
    check(!lock_o, "R6", "lock lost after 4th bad", lock_o, 0);

    // unlocked, hidden
    oss_i = 1'b0;
    ok = 1;
    fork
      send_random(5);
      repeat (130) begin
        @(posedge clk_i); #2;
        if (data_o != 0 || valid_o || lock_o) ok = 0;
      end
    join
    check(ok, "R9", "unlocked hidden output zero", ok, 1);

    // unlocked, pass-through
    oss_i = 1'b1;
    ok = 1;
    nz = 0;
    fork
      send_random(5);
      repeat (130) begin
        @(posedge clk_i); #2;
        if (valid_o || lock_o) ok = 0;
        if (data_o != 0) nz = 1;
      end
    join
    check(ok, "R9", "no strobe while unlocked", ok, 1);
    check(nz, "R9", "pass-through shows data", nz, 1);
    oss_i = 1'b0;

    // reacquire after one-bit shift
    for (int k = 0; k < 80 && !lock_o; k++) send_random(1);
    @(posedge clk_i); #2;
    check(lock_o, "R3", "relock after slip", lock_o, 1);
    v0 = valid_count;
    send_random(10);
    check(valid_count - v0 >= 9, "R3", "strobes after relock", valid_count - v0, 10);

    // output blanking
    oe_i = 1'b0;
    ok = 1;
    fork
      send_random(3);
      repeat (80) begin
        @(posedge clk_i); #2;
        if (data_o != 0 || side_o != 0 || valid_o || err_o) ok = 0;
        if (!lock_o) ok = 0;
      end
    join
    check(ok, "R10", "blanked outputs with lock kept", ok, 1);
    oe_i = 1'b1;
    send_random(2);

    // power-down, then reacquire from a random offset
    pd_i = 1'b1;
    @(posedge clk_i); #2;
    check(!lock_o, "R11", "lock drops on power-down", lock_o, 0);
    repeat (10) @(posedge clk_i);
    #2;
    check(!lock_o && !valid_o, "R11", "held while powered down", lock_o, 0);
    pd_i = 1'b0;
    begin
      int junk;
      junk = 1 + ($urandom % 27);
      repeat (junk) begin
        @(negedge clk_i);
        ser_i = $urandom & 1;
      end
    end
    for (int k = 0; k < 80 && !lock_o; k++) send_random(1);
    @(posedge clk_i); #2;
    check(lock_o, "R11", "relock after power-down", lock_o, 1);
    v0 = valid_count;
    send_random(12);
    check(valid_count - v0 >= 11, "R11", "strobes after power-down relock", valid_count - v0, 12);

    finish_run();
  end
endmodule